// File: doc/BRIEF.md
# PC Card Host Access Decoder

This block sits behind the card edge of a serial-port PC card. It watches the active-low strobes the host drives (two card enables, the attribute select, memory output and write enables, I/O read and I/O write) together with a 10-bit address and an 8-bit write data bus. From these it produces clean internal selects toward two targets: a 256-entry attribute memory, and the eight-register file of the UART.

The block also does three things on the host side. It folds the two card enables and address bit 0 into a single byte address, so that an 8-bit host reaches every byte over the low data lines. It drives the host read data and its output enable. It pulls the I/O acknowledge low while it answers an I/O read.

Reads are combinational and follow the strobes within the same cycle. Writes are held until the host releases its write strobe, and are then issued as a one-cycle pulse. If the host asserts more than one strobe at a time, the block treats that as a bus error and performs no access.

Top module: `pccard_host_decoder`

## Requirements
- R1: While `rst_n` is low and after reset with all strobes high: `am_rd`, `ur_rd`, `am_wr`, `ur_wr` and `host_rdata_oe` are 0, `io_ack_n` is 1 and `host_rdata` is 0.
- R2: The effective byte address keeps `host_addr[9:1]`. Its bit 0 is set as follows: with `ce1_n`=0 and `ce2_n`=1 it is `host_addr[0]`; with `ce1_n`=1 and `ce2_n`=0 it is forced to 1; with both enables low it is forced to 0. With both enables high, no access of any kind takes place.
- R3: An attribute read is `reg_n`=0 with `oe_n` as the only low strobe and a card enable low. For an even effective address, `am_rd`=1, `am_raddr` = effective address bits 8..1 (bit 9 is ignored), `host_rdata`=`am_rdata` and `host_rdata_oe`=1. For an odd effective address, `am_rd`=0 and `host_rdata_oe`=1 with data 0x00.
- R4: With `reg_n`=1, no strobe causes a read select, a write pulse, `host_rdata_oe` or acknowledge.
- R5: An I/O read is `reg_n`=0 with `iord_n` as the only low strobe, a card enable low and an address hit. It gives `ur_rd`=1, `ur_raddr` = effective address bits 2..0, `host_rdata`=`ur_rdata` and `host_rdata_oe`=1.
- R6: `io_ack_n` is 0 exactly during a decoded I/O read (R5). It is never low for a memory access or an I/O write.
- R7: With `com_mode`=0 every I/O address hits. With `com_mode`=1 an I/O access hits only when effective address bits 9..3 equal `COM_BASE[9:3]` (default 0x3F8); a miss gives no select, no pulse and no acknowledge.
- R8: Each clock edge that sees a decoded write (`we_n` alone on an even attribute address, or `iowr_n` alone with an I/O hit) captures the effective address and `host_wdata`. At the first later edge with `we_n` and `iowr_n` both high, exactly one of `am_wr`/`ur_wr` pulses for one cycle. `wr_index` is then attribute address bits 8..1, or {5'b0, bits 2..0} for I/O, and `wr_data` holds the last captured data. Odd attribute writes produce no pulse.
- R9: When more than one of `oe_n`, `we_n`, `iord_n`, `iowr_n` is low, there is no read select, no output enable and no acknowledge, and a captured write that has not yet been issued is discarded.
- R10: `host_rdata_oe` and the read selects follow the strobes in the same cycle, with no clock edge in between; releasing the strobe drops them at once.
- R11: At most one of `am_rd`/`ur_rd`, and at most one of `am_wr`/`ur_wr`, is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce1_n | input | 1 | Card enable, even byte lane |
| ce2_n | input | 1 | Card enable, odd byte lane |
| reg_n | input | 1 | Attribute/I/O space select |
| oe_n | input | 1 | Memory output enable |
| we_n | input | 1 | Memory write enable |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| com_mode | input | 1 | 1: full 10-bit I/O decode against COM_BASE |
| host_addr | input | 10 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Read data drive enable |
| io_ack_n | output | 1 | I/O read acknowledge, active low |
| am_rd | output | 1 | Attribute memory read select |
| am_raddr | output | 8 | Attribute memory read index |
| am_rdata | input | 8 | Attribute memory read data |
| ur_rd | output | 1 | UART register read select |
| ur_raddr | output | 3 | UART register read index |
| ur_rdata | input | 8 | UART register read data |
| am_wr | output | 1 | Attribute memory write pulse |
| ur_wr | output | 1 | UART register write pulse |
| wr_index | output | 8 | Write index for the pulsed target |
| wr_data | output | 8 | Write data for the pulsed target |

## Verification
The bound checker watches several properties on every clock edge. It checks that the acknowledge and output enable appear only under a single valid strobe with the attribute select low. It checks that nothing decodes with the card disabled, that a bus conflict silences every read path, and that the read and write selects stay exclusive. It also checks that a write pulse lasts one cycle and follows an edge where both write strobes were high.

The routing of bytes is shown only by the bench's scenarios. These include the enable-driven steering of address bit 0, the zero returned for odd attribute bytes, and the COM-base hit and miss decode. The bench scenarios also cover which data a held write finally commits, and the loss of a pending write to a conflict.

// File: rtl/pccard_host_decoder.sv
module pccard_host_decoder #(
  parameter logic [9:0] COM_BASE = 10'h3F8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       reg_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       iord_n,
  input  logic       iowr_n,
  input  logic       com_mode,
  input  logic [9:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       host_rdata_oe,
  output logic       io_ack_n,
  output logic       am_rd,
  output logic [7:0] am_raddr,
  input  logic [7:0] am_rdata,
  output logic       ur_rd,
  output logic [2:0] ur_raddr,
  input  logic [7:0] ur_rdata,
  output logic       am_wr,
  output logic       ur_wr,
  output logic [7:0] wr_index,
  output logic [7:0] wr_data
);

  logic       card_on, multi, sel, io_hit, even;
  logic       mem_rd, mem_wr, io_rd, io_wr, wr_idle;
  logic [9:0] byte_a;
  logic [2:0] nstb;

  logic       pend_q, pend_io_q;
  logic [9:0] pend_addr_q;
  logic [7:0] pend_data_q;

  assign card_on = !ce1_n || !ce2_n;
  assign byte_a  = {host_addr[9:1], ce1_n ? 1'b1 : (ce2_n ? host_addr[0] : 1'b0)};
  assign nstb    = 3'(!oe_n) + 3'(!we_n) + 3'(!iord_n) + 3'(!iowr_n);
  assign multi   = nstb > 3'd1;
  assign sel     = !reg_n && card_on && !multi;
  assign io_hit  = !com_mode || (byte_a[9:3] == COM_BASE[9:3]);
  assign even    = !byte_a[0];

  assign mem_rd  = sel && !oe_n;
  assign mem_wr  = sel && !we_n && even;
  assign io_rd   = sel && !iord_n && io_hit;
  assign io_wr   = sel && !iowr_n && io_hit;
  assign wr_idle = we_n && iowr_n;

  assign am_rd         = mem_rd && even;
  assign am_raddr      = byte_a[8:1];
  assign ur_rd         = io_rd;
  assign ur_raddr      = byte_a[2:0];
  assign host_rdata_oe = mem_rd || io_rd;
  assign io_ack_n      = !io_rd;
  assign host_rdata    = io_rd ? ur_rdata : (am_rd ? am_rdata : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_io_q   <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      am_wr       <= 1'b0;
      ur_wr       <= 1'b0;
      wr_index    <= '0;
      wr_data     <= '0;
    end else begin
      am_wr <= 1'b0;
      ur_wr <= 1'b0;
      if (multi) begin
        pend_q <= 1'b0;
      end else if (mem_wr || io_wr) begin
        pend_q      <= 1'b1;
        pend_io_q   <= io_wr;
        pend_addr_q <= byte_a;
        pend_data_q <= host_wdata;
      end else if (pend_q && wr_idle) begin
        pend_q   <= 1'b0;
        am_wr    <= !pend_io_q;
        ur_wr    <= pend_io_q;
        wr_index <= pend_io_q ? {5'b0, pend_addr_q[2:0]} : pend_addr_q[8:1];
        wr_data  <= pend_data_q;
      end
    end
  end

endmodule

// File: rtl/pccard_host_decoder_chk.sv
module pccard_host_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic ce1_n,
  input logic ce2_n,
  input logic reg_n,
  input logic oe_n,
  input logic we_n,
  input logic iord_n,
  input logic iowr_n,
  input logic host_rdata_oe,
  input logic io_ack_n,
  input logic am_rd,
  input logic ur_rd,
  input logic am_wr,
  input logic ur_wr
);

  AST_ACK_ONLY_IORD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_ack_n |-> (!iord_n && oe_n && we_n && iowr_n && !reg_n)); // R6

  AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata_oe |-> (!reg_n && ((!oe_n && iord_n) || (oe_n && !iord_n)))); // R10

  AST_NO_CARD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ce2_n) |-> (!am_rd && !ur_rd && !host_rdata_oe && io_ack_n)); // R2

  AST_ATTR_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    reg_n |-> (!am_rd && !ur_rd && !host_rdata_oe && io_ack_n)); // R4

  AST_CONFLICT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({!oe_n, !we_n, !iord_n, !iowr_n}) > 1) |->
      (!am_rd && !ur_rd && !host_rdata_oe && io_ack_n)); // R9

  AST_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({am_rd, ur_rd})); // R11

  AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({am_wr, ur_wr})); // R11

  AST_AM_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    am_wr |=> !am_wr); // R8

  AST_UR_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ur_wr |=> !ur_wr); // R8

  AST_WR_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (am_wr || ur_wr) |-> ($past(we_n) && $past(iowr_n))); // R8

endmodule

bind pccard_host_decoder pccard_host_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
  .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
  .host_rdata_oe(host_rdata_oe), .io_ack_n(io_ack_n),
  .am_rd(am_rd), .ur_rd(ur_rd), .am_wr(am_wr), .ur_wr(ur_wr)
);

// File: tb/sim_pccard_host_decoder.sv
`timescale 1ns/1ps
module sim_pccard_host_decoder;
  localparam logic [9:0] BASE = 10'h3F8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce1_n = 1, ce2_n = 1, reg_n = 1, oe_n = 1, we_n = 1, iord_n = 1, iowr_n = 1, com_mode = 0;
  logic [9:0] host_addr = '0;
  logic [7:0] host_wdata = '0, am_rdata = 8'h11, ur_rdata = 8'h22;
  logic [7:0] host_rdata, am_raddr, wr_index, wr_data;
  logic [2:0] ur_raddr;
  logic host_rdata_oe, io_ack_n, am_rd, ur_rd, am_wr, ur_wr;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pccard_host_decoder #(.COM_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n),
    .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n), .com_mode(com_mode),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .io_ack_n(io_ack_n), .am_rd(am_rd), .am_raddr(am_raddr),
    .am_rdata(am_rdata), .ur_rd(ur_rd), .ur_raddr(ur_raddr), .ur_rdata(ur_rdata),
    .am_wr(am_wr), .ur_wr(ur_wr), .wr_index(wr_index), .wr_data(wr_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic c1, input logic c2, input logic rg, input logic o,
                       input logic w, input logic ir, input logic iw,
                       input logic [9:0] a, input logic [7:0] d);
    ce1_n = c1; ce2_n = c2; reg_n = rg; oe_n = o; we_n = w; iord_n = ir; iowr_n = iw;
    host_addr = a; host_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 8'h0);
  endtask

  function automatic logic [9:0] eff(input logic c1, input logic c2, input logic [9:0] a);
    if (!c1 && c2) return a;
    if (c1 && !c2) return {a[9:1], 1'b1};
    return {a[9:1], 1'b0};
  endfunction

  logic mp, mio, eam, eur;
  logic [9:0] maddr;
  logic [7:0] mdata, eidx, edata;

  initial begin
    #8000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", host_rdata_oe, 0);
    chk("R1 ack in reset", io_ack_n, 1);
    chk("R1 wr in reset", {am_wr, ur_wr, am_rd, ur_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle rdata", host_rdata, 0);
    chk("R1 idle selects", {am_rd, ur_rd, am_wr, ur_wr, host_rdata_oe, io_ack_n}, 6'b000001);

    // steering and attribute reads
    am_rdata = 8'hC3;
    @(negedge clk); drive(0, 1, 0, 0, 1, 1, 1, 10'h012, 0); #1;
    chk("R2 ce1 even am_raddr", am_raddr, 8'h09);
    chk("R3 even read data", host_rdata, 8'hC3);
    chk("R3 even read oe", {am_rd, host_rdata_oe, io_ack_n}, 3'b111);
    @(negedge clk); drive(0, 1, 0, 0, 1, 1, 1, 10'h011, 0); #1;
    chk("R3 odd attr read", {am_rd, host_rdata_oe, host_rdata}, {1'b0, 1'b1, 8'h00});
    @(negedge clk); drive(1, 0, 0, 0, 1, 1, 1, 10'h010, 0); #1;
    chk("R2 ce2 forces odd", {am_rd, host_rdata}, 9'h000);
    @(negedge clk); drive(0, 0, 0, 0, 1, 1, 1, 10'h011, 0); #1;
    chk("R2 both forces even", {am_rd, am_raddr}, {1'b1, 8'h08});
    @(negedge clk); drive(0, 1, 0, 0, 1, 1, 1, 10'h3FE, 0); #1;
    chk("R3 bit9 ignored", am_raddr, 8'hFF);
    @(negedge clk); drive(1, 1, 0, 0, 1, 1, 1, 10'h010, 0); #1;
    chk("R2 no card enable", {am_rd, host_rdata_oe}, 0);
    @(negedge clk); drive(0, 1, 1, 0, 1, 1, 1, 10'h010, 0); #1;
    chk("R4 reg high mem read", {am_rd, host_rdata_oe}, 0);
    @(negedge clk); drive(0, 1, 1, 1, 1, 0, 1, 10'h010, 0); #1;
    chk("R4 reg high io read", {ur_rd, io_ack_n}, 2'b01);
    @(negedge clk); drive(0, 1, 0, 1, 1, 1, 1, 10'h010, 0); #1;
    chk("R10 oe released same cycle", host_rdata_oe, 0);

    // I/O reads
    ur_rdata = 8'h5E;
    @(negedge clk); drive(1, 0, 0, 1, 1, 0, 1, 10'h000, 0); #1;
    chk("R5 card mode io read idx", ur_raddr, 3'd1);
    chk("R5 io read data", host_rdata, 8'h5E);
    chk("R6 ack on io read", {ur_rd, io_ack_n, host_rdata_oe}, 3'b101);
    @(negedge clk); drive(0, 1, 0, 1, 1, 1, 1, 10'h000, 0); #1;
    chk("R10 ack released", io_ack_n, 1);
    @(negedge clk); drive(0, 1, 0, 1, 1, 1, 0, 10'h004, 8'h77); #1;
    chk("R6 no ack on io write", io_ack_n, 1);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    @(negedge clk); com_mode = 1;
    drive(0, 1, 0, 1, 1, 0, 1, BASE + 10'd5, 0); #1;
    chk("R7 com hit", {ur_rd, ur_raddr, io_ack_n}, {1'b1, 3'd5, 1'b0});
    @(negedge clk); drive(0, 1, 0, 1, 1, 0, 1, 10'h2FD, 0); #1;
    chk("R7 com miss", {ur_rd, io_ack_n, host_rdata_oe}, 3'b010);
    @(negedge clk); drive(0, 1, 0, 1, 1, 1, 0, 10'h2F9, 8'h44);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    @(negedge clk); chk("R7 com miss write", {am_wr, ur_wr}, 0);
    @(negedge clk); chk("R7 com miss write later", {am_wr, ur_wr}, 0);

    // writes
    @(negedge clk); drive(0, 1, 0, 1, 0, 1, 1, 10'h020, 8'h5A);
    @(negedge clk); host_wdata = 8'hA5;
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 8'hFF);
    chk("R8 no pulse while held", am_wr, 0);
    @(negedge clk);
    chk("R8 attr pulse", {am_wr, ur_wr, wr_index, wr_data}, {2'b10, 8'h10, 8'hA5});
    @(negedge clk);
    chk("R8 pulse one cycle", {am_wr, ur_wr}, 0);
    @(negedge clk); drive(0, 0, 0, 1, 1, 1, 0, BASE + 10'd3, 8'h3C);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    @(negedge clk);
    chk("R8 io pulse", {am_wr, ur_wr, wr_index, wr_data}, {2'b01, 8'h02, 8'h3C});
    @(negedge clk); drive(0, 1, 0, 1, 0, 1, 1, 10'h023, 8'h99);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    @(negedge clk); chk("R8 odd attr write dropped", am_wr, 0);

    // conflicts
    @(negedge clk); drive(0, 1, 0, 1, 0, 0, 1, 10'h020, 8'h12); #1;
    chk("R9 conflict no read", {am_rd, ur_rd, host_rdata_oe, io_ack_n}, 4'b0001);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    @(negedge clk); chk("R9 conflict no write", {am_wr, ur_wr}, 0);
    @(negedge clk); drive(0, 1, 0, 1, 0, 1, 1, 10'h040, 8'h66);
    @(negedge clk); drive(0, 1, 0, 0, 1, 0, 1, 10'h040, 8'h66);
    @(negedge clk); drive(1, 1, 1, 1, 1, 1, 1, 10'h0, 0);
    chk("R9 pending not issued", am_wr, 0);
    @(negedge clk); chk("R9 pending discarded", {am_wr, ur_wr}, 0);
    idle(); idle();

    // constrained random against bench model
    mp = 0; mio = 0; maddr = 0; mdata = 0; eam = 0; eur = 0; eidx = 0; edata = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] stb;
      logic [9:0] a, ea;
      logic multi, sel, hit, ev, mrd, mwr, ird, iwr;
      int unsigned r;
      @(negedge clk);
      chk("R8 rand am_wr", am_wr, eam);
      chk("R8 rand ur_wr", ur_wr, eur);
      if (eam || eur) begin
        chk("R8 rand wr_index", wr_index, eidx);
        chk("R8 rand wr_data", wr_data, edata);
      end
      if (i % 500 == 0) com_mode = $urandom_range(0, 1);
      r = $urandom_range(0, 9);
      if (r < 7) stb = ~(4'b1 << $urandom_range(0, 3));
      else if (r == 7) stb = 4'hF;
      else stb = 4'($urandom);
      a = 10'($urandom);
      if ($urandom_range(0, 1)) a[9:3] = BASE[9:3];
      am_rdata = 8'($urandom); ur_rdata = 8'($urandom);
      drive(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0),
            1'($urandom_range(0, 4) == 0), stb[0], stb[1], stb[2], stb[3], a, 8'($urandom));
      #1;
      ea    = eff(ce1_n, ce2_n, a);
      multi = $countones(~stb) > 1;
      sel   = !reg_n && !(ce1_n && ce2_n) && !multi;
      hit   = !com_mode || ea[9:3] == BASE[9:3];
      ev    = !ea[0];
      mrd = sel && !oe_n;  mwr = sel && !we_n && ev;
      ird = sel && !iord_n && hit; iwr = sel && !iowr_n && hit;
      chk("R3 rand am_rd", am_rd, mrd && ev);
      if (mrd && ev) chk("R3 rand am_raddr", am_raddr, ea[8:1]);
      chk("R5 rand ur_rd", ur_rd, ird);
      if (ird) chk("R5 rand ur_raddr", ur_raddr, ea[2:0]);
      chk("R6 rand ack", io_ack_n, !ird);
      chk("R10 rand oe", host_rdata_oe, mrd || ird);
      chk("R3 rand rdata", host_rdata, ird ? ur_rdata : ((mrd && ev) ? am_rdata : 8'h00));
      eam = 0; eur = 0;
      if (multi) mp = 0;
      else if (mwr || iwr) begin mp = 1; mio = iwr; maddr = ea; mdata = host_wdata; end
      else if (mp && we_n && iowr_n) begin
        eam = !mio; eur = mio; edata = mdata;
        eidx = mio ? {5'b0, maddr[2:0]} : maddr[8:1];
        mp = 0;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule